// File: doc/BRIEF.md
# Overlay Window Alpha Selector

This unit sits in one overlay plane of a display compositing pipeline and runs once per screen pixel. For each pixel it receives the screen coordinate, the pixel word that was fetched for the overlay, the pixel's alpha-enable bit and a colour-key area flag from an upstream key matcher. It then decides whether the coordinate falls inside the enabled overlay rectangle. If it does, it picks the 4-bit-per-channel blend factor (red, green, blue) that the downstream blender should use.

Two constant alpha triples, the rectangle corners and a small control word are loaded through a simple write port. The blend factor comes from one of the two constant triples, or from a 4-bit alpha carried in the pixel word itself. Which source is used depends on the plane-versus-pixel blending mode, the alpha-select bit, the alpha-enable bit, the key-blend control and the colour-key result. The result is registered one cycle after a pixel strobe and is forced to zero whenever the pixel misses the window.

Top module: `ovl_alpha_sel`

## Requirements
- R1: Reset is synchronous and active high. After reset, every configuration field is zero, so the window is disabled. After reset, `out_valid`, `out_hit`, `out_alpha` and `cfg_misalign` are all zero.
- R2: A write with `cfg_we` high loads the configuration word selected by `cfg_addr`, and the new value takes effect from the next cycle. The addresses and fields are:
  - Address 0 is the control word: bit 0 enables the window, bit 1 is alpha-select, bit 2 selects per-pixel mode (1) or per-plane mode (0), bit 3 enables key-blend, and bits [5:4] give the format (0 = 8bpp, 1 = 16bpp, 2 = 24bpp, 3 = 28bpp).
  - Address 1 is the top-left corner, with X in bits [21:11] and Y in bits [10:0].
  - Address 2 is the bottom-right corner, with the same layout.
  - Address 3 holds the first triple in bits [11:0] and the second triple in bits [23:12]. Each triple is packed as R in [11:8], G in [7:4] and B in [3:0].
- R3: A pixel hits when the window is enabled, left X ≤ x ≤ right X and top Y ≤ y ≤ bottom Y. All four bounds are inclusive.
- R4: While the enable bit is 0, no pixel hits and the output alpha is zero.
- R5: In per-plane mode, alpha-select 0 yields the first triple and alpha-select 1 yields the second triple. The alpha-enable bit and the key flag have no effect in this mode.
- R6: In per-pixel mode with alpha-select 0 and key-blend off, alpha-enable 0 yields the first triple and alpha-enable 1 yields the second triple.
- R7: In per-pixel mode with alpha-select 0 and key-blend on, a pixel outside the key area yields the first triple and a pixel inside it yields the second triple. The alpha-enable bit is then ignored.
- R8: In per-pixel mode with alpha-select 1 and the 28bpp format, bits [27:24] of the pixel word are used as the alpha on all three channels.
- R9: In per-pixel mode with alpha-select 1 and any format other than 28bpp, the first triple is used.
- R10: `cfg_misalign` is 1 when the left X is not a multiple of 4 at 8bpp, or not a multiple of 2 at 16bpp. It is never 1 at 24bpp or 28bpp. The hit test treats those low left-X bits as zero.
- R11: `out_valid` equals `px_valid` delayed by one cycle. When there is no hit, or no valid pixel, `out_hit` is 0 and `out_alpha` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 24 | Configuration write data |
| px_valid | input | 1 | Pixel strobe |
| px_x | input | 11 | Screen X of the pixel |
| px_y | input | 11 | Screen Y of the pixel |
| px_word | input | 32 | Fetched overlay pixel word |
| px_aen | input | 1 | Per-pixel alpha-enable bit |
| px_key_area | input | 1 | Pixel lies in the colour-key area |
| out_valid | output | 1 | Registered pixel strobe |
| out_hit | output | 1 | Pixel is inside the enabled window |
| out_alpha | output | 12 | Selected alpha, R [11:8], G [7:4], B [3:0] |
| cfg_misalign | output | 1 | Left X is not on a word boundary for the format |

## Verification
The assertions assume that the configuration is not rewritten in the same cycle as a pixel whose result they track. They also assume that the mode and format fields hold legal encodings, which every value of a 2-bit format field does. The stimulus respects this: each configuration write completes a full cycle before the pixel strobe that depends on it, and every pixel is followed by a check before the next write. The per-plane and embedded-alpha properties compare against the previous cycle's inputs, so the bench holds `px_valid` for only one cycle per pixel.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int COORD_W  = 11;
    localparam int ALPHA_W  = 4;
    localparam int PIX_W    = 32;
    localparam int EMB_LSB  = 24;
    localparam int TRIPLE_W = 3 * ALPHA_W;
    localparam int CFG_W    = (2 * COORD_W > 2 * TRIPLE_W) ? 2 * COORD_W : 2 * TRIPLE_W;

    typedef enum logic [1:0] {
        FMT_8  = 2'd0,
        FMT_16 = 2'd1,
        FMT_24 = 2'd2,
        FMT_28 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_TOPL  = 2'd1,
        REG_BOTR  = 2'd2,
        REG_ALPHA = 2'd3
    } reg_sel_e;

    typedef struct packed {
        fmt_e fmt;
        logic key_blend;
        logic pix_mode;
        logic alpha_sel;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [ALPHA_W-1:0] r;
        logic [ALPHA_W-1:0] g;
        logic [ALPHA_W-1:0] b;
    } triple_t;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } corner_t;

    // Low X bits that must be zero for a word-aligned window edge.
    function automatic logic [1:0] x_low_mask(fmt_e f);
        case (f)
            FMT_8:   return 2'b11;
            FMT_16:  return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
    import ovl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CFG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output corner_t          top_left,
    output corner_t          bot_right,
    output triple_t          alpha0,
    output triple_t          alpha1
);

    localparam int POS_W = 2 * COORD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            top_left  <= '0;
            bot_right <= '0;
            alpha0    <= '0;
            alpha1    <= '0;
        end else if (we) begin
            case (reg_sel_e'(addr))
                REG_CTRL:  ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
                REG_TOPL:  top_left  <= corner_t'(wdata[POS_W-1:0]);
                REG_BOTR:  bot_right <= corner_t'(wdata[POS_W-1:0]);
                REG_ALPHA: begin
                    alpha0 <= triple_t'(wdata[TRIPLE_W-1:0]);
                    alpha1 <= triple_t'(wdata[2*TRIPLE_W-1:TRIPLE_W]);
                end
                default: ;
            endcase
        end
    end

    logic unused_hi;
    assign unused_hi = ^wdata;

    // R1: the window comes out of reset switched off
    assert_off_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl.enable == 1'b0 && top_left == '0 && bot_right == '0));

    // R2: a control write is visible on the following cycle
    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == 2'd0) |=> (ctrl == ctrl_t'($past(wdata[CTRL_W-1:0]))));

endmodule

// File: rtl/ovl_win_hit.sv
module ovl_win_hit
    import ovl_pkg::*;
(
    input  ctrl_t              ctrl,
    input  corner_t            top_left,
    input  corner_t            bot_right,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    output logic               hit,
    output logic               misalign
);

    logic [1:0]         low_mask;
    logic [COORD_W-1:0] mask_vec;
    logic [COORD_W-1:0] left_eff;
    logic               in_x;
    logic               in_y;

    always_comb begin
        low_mask = x_low_mask(ctrl.fmt);
        mask_vec = COORD_W'(low_mask);
        left_eff = top_left.x & ~mask_vec;
        misalign = |(top_left.x & mask_vec);
        in_x     = (x >= left_eff) && (x <= bot_right.x);
        in_y     = (y >= top_left.y) && (y <= bot_right.y);
        hit      = ctrl.enable && in_x && in_y;
    end

    // R10: formats without a packing restriction never raise the flag
    always_comb begin
        if (ctrl.fmt == FMT_24 || ctrl.fmt == FMT_28)
            assert_wide_fmt_aligned_R10: assert (!misalign);
    end

endmodule

// File: rtl/ovl_alpha_pick.sv
module ovl_alpha_pick
    import ovl_pkg::*;
(
    input  ctrl_t            ctrl,
    input  triple_t          alpha0,
    input  triple_t          alpha1,
    input  logic [PIX_W-1:0] word,
    input  logic             aen,
    input  logic             key_area,
    output triple_t          alpha
);

    logic [ALPHA_W-1:0] emb;
    logic               use_second;

    assign emb = word[EMB_LSB +: ALPHA_W];

    always_comb begin
        use_second = 1'b0;
        alpha      = alpha0;
        if (!ctrl.pix_mode) begin
            use_second = ctrl.alpha_sel;
            alpha      = use_second ? alpha1 : alpha0;
        end else if (!ctrl.alpha_sel) begin
            use_second = ctrl.key_blend ? key_area : aen;
            alpha      = use_second ? alpha1 : alpha0;
        end else if (ctrl.fmt == FMT_28) begin
            alpha = '{r: emb, g: emb, b: emb};
        end else begin
            alpha = alpha0;
        end
    end

    logic unused_word;
    assign unused_word = ^{word[PIX_W-1:EMB_LSB+ALPHA_W], word[EMB_LSB-1:0]};

endmodule

// File: rtl/ovl_alpha_sel.sv
module ovl_alpha_sel
    import ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_addr,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  px_valid,
    input  logic [COORD_W-1:0]    px_x,
    input  logic [COORD_W-1:0]    px_y,
    input  logic [PIX_W-1:0]      px_word,
    input  logic                  px_aen,
    input  logic                  px_key_area,
    output logic                  out_valid,
    output logic                  out_hit,
    output logic [TRIPLE_W-1:0]   out_alpha,
    output logic                  cfg_misalign
);

    ctrl_t   ctrl;
    corner_t top_left;
    corner_t bot_right;
    triple_t alpha0;
    triple_t alpha1;
    triple_t alpha_c;
    logic    hit_c;

    ovl_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ctrl      (ctrl),
        .top_left  (top_left),
        .bot_right (bot_right),
        .alpha0    (alpha0),
        .alpha1    (alpha1)
    );

    ovl_win_hit u_hit (
        .ctrl      (ctrl),
        .top_left  (top_left),
        .bot_right (bot_right),
        .x         (px_x),
        .y         (px_y),
        .hit       (hit_c),
        .misalign  (cfg_misalign)
    );

    ovl_alpha_pick u_pick (
        .ctrl      (ctrl),
        .alpha0    (alpha0),
        .alpha1    (alpha1),
        .word      (px_word),
        .aen       (px_aen),
        .key_area  (px_key_area),
        .alpha     (alpha_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_alpha <= '0;
        end else begin
            out_valid <= px_valid;
            out_hit   <= px_valid && hit_c;
            out_alpha <= (px_valid && hit_c) ? TRIPLE_W'(alpha_c) : '0;
        end
    end

    // R11: output strobe trails the input strobe by one cycle
    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
        px_valid |=> out_valid);

    assert_idle_follow_R11: assert property (@(posedge clk) disable iff (rst)
        !px_valid |=> (!out_valid && !out_hit));

    // R11: a miss carries no alpha
    assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_alpha == '0));

    // R4: a disabled window never reports a hit
    assert_off_no_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (px_valid && !ctrl.enable) |=> !out_hit);

    // R5: per-plane mode with select 0 passes the first triple through
    assert_plane_first_R5: assert property (@(posedge clk) disable iff (rst)
        (px_valid && hit_c && !ctrl.pix_mode && !ctrl.alpha_sel && !cfg_we)
        |=> (out_alpha == $past(alpha0)));

    // R8: embedded alpha is replicated on all channels
    assert_embedded_R8: assert property (@(posedge clk) disable iff (rst)
        (px_valid && hit_c && ctrl.pix_mode && ctrl.alpha_sel && ctrl.fmt == FMT_28)
        |=> (out_alpha == {3{$past(px_word[EMB_LSB +: ALPHA_W])}}));

endmodule

// File: tb/sim_ovl_alpha_sel.sv
module sim_ovl_alpha_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [23:0] cfg_wdata;
    logic        px_valid;
    logic [10:0] px_x;
    logic [10:0] px_y;
    logic [31:0] px_word;
    logic        px_aen;
    logic        px_key_area;
    logic        out_valid;
    logic        out_hit;
    logic [11:0] out_alpha;
    logic        cfg_misalign;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ovl_alpha_sel u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
        .px_word(px_word), .px_aen(px_aen), .px_key_area(px_key_area),
        .out_valid(out_valid), .out_hit(out_hit), .out_alpha(out_alpha),
        .cfg_misalign(cfg_misalign)
    );

    typedef struct packed {
        logic [5:0]  ctrl;
        logic [10:0] x;
        logic [10:0] y;
        logic        aen;
        logic        key;
        logic [3:0]  nib;
        logic        hit;
        logic [11:0] alpha;
    } vec_t;

    localparam int NV = 18;
    // window (12,20)-(40,50); first triple 123, second ABC
    localparam vec_t VECS [NV] = '{
        '{6'h21, 11'd12, 11'd20, 1'b0, 1'b0, 4'h0, 1'b1, 12'h123}, // R3 R5 corner
        '{6'h23, 11'd40, 11'd50, 1'b0, 1'b0, 4'h0, 1'b1, 12'hABC}, // R3 R5
        '{6'h21, 11'd41, 11'd30, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R3 right
        '{6'h21, 11'd11, 11'd30, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R3 left
        '{6'h21, 11'd20, 11'd51, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R3 bottom
        '{6'h21, 11'd20, 11'd19, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R3 top
        '{6'h21, 11'd20, 11'd30, 1'b1, 1'b1, 4'h0, 1'b1, 12'h123}, // R5 ignores aen/key
        '{6'h25, 11'd20, 11'd30, 1'b0, 1'b1, 4'h0, 1'b1, 12'h123}, // R6 aen0
        '{6'h25, 11'd20, 11'd30, 1'b1, 1'b0, 4'h0, 1'b1, 12'hABC}, // R6 aen1
        '{6'h2D, 11'd20, 11'd30, 1'b1, 1'b0, 4'h0, 1'b1, 12'h123}, // R7 non-key
        '{6'h2D, 11'd20, 11'd30, 1'b0, 1'b1, 4'h0, 1'b1, 12'hABC}, // R7 key
        '{6'h37, 11'd20, 11'd30, 1'b0, 1'b0, 4'h7, 1'b1, 12'h777}, // R8
        '{6'h37, 11'd40, 11'd50, 1'b1, 1'b1, 4'hF, 1'b1, 12'hFFF}, // R8
        '{6'h17, 11'd20, 11'd30, 1'b1, 1'b0, 4'h9, 1'b1, 12'h123}, // R9 16bpp
        '{6'h27, 11'd20, 11'd30, 1'b0, 1'b1, 4'h9, 1'b1, 12'h123}, // R9 24bpp
        '{6'h20, 11'd20, 11'd30, 1'b0, 1'b0, 4'h0, 1'b0, 12'h000}, // R4
        '{6'h36, 11'd20, 11'd30, 1'b0, 1'b0, 4'h5, 1'b0, 12'h000}, // R4
        '{6'h37, 11'd41, 11'd30, 1'b0, 1'b0, 4'h5, 1'b0, 12'h000}  // R11 miss
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one pixel, then sample at the next falling edge
    task automatic pix(input logic [10:0] x, input logic [10:0] y, input logic a,
                       input logic k, input logic [3:0] nib);
        px_valid = 1'b1; px_x = x; px_y = y; px_aen = a; px_key_area = k;
        px_word = {4'h0, nib, 24'h5A5A5A};
        @(negedge clk);
        px_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        px_valid = 1'b0; px_x = '0; px_y = '0; px_word = '0;
        px_aen = 1'b0; px_key_area = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_alpha", 32'(out_alpha), 32'd0);
        chk("R1 misalign", 32'(cfg_misalign), 32'd0);
        pix(11'd0, 11'd0, 1'b0, 1'b0, 4'h0);
        chk("R1 disabled at reset hit", 32'(out_hit), 32'd0);
        chk("R11 valid follows", 32'(out_valid), 32'd1);

        wr(2'd1, 24'((12 << 11) | 20));
        wr(2'd2, 24'((40 << 11) | 50));
        wr(2'd3, 24'hABC123);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 24'(VECS[i].ctrl));
            pix(VECS[i].x, VECS[i].y, VECS[i].aen, VECS[i].key, VECS[i].nib);
            chk($sformatf("R2 R11 vec%0d valid", i), 32'(out_valid), 32'd1);
            chk($sformatf("R3 vec%0d hit", i), 32'(out_hit), 32'(VECS[i].hit));
            chk($sformatf("R5-9 vec%0d alpha", i), 32'(out_alpha), 32'(VECS[i].alpha));
        end

        // R11: no strobe gives nothing even inside the window
        wr(2'd0, 24'h21);
        px_x = 11'd20; px_y = 11'd30;
        @(negedge clk);
        chk("R11 idle valid", 32'(out_valid), 32'd0);
        chk("R11 idle alpha", 32'(out_alpha), 32'd0);

        // R10: misaligned left edge at 8bpp
        wr(2'd1, 24'((13 << 11) | 20));
        wr(2'd0, 24'h01);
        chk("R10 8bpp flag", 32'(cfg_misalign), 32'd1);
        pix(11'd12, 11'd30, 1'b0, 1'b0, 4'h0);
        chk("R10 masked hit", 32'(out_hit), 32'd1);
        chk("R10 masked alpha", 32'(out_alpha), 32'h123);
        pix(11'd11, 11'd30, 1'b0, 1'b0, 4'h0);
        chk("R10 below mask", 32'(out_hit), 32'd0);
        wr(2'd0, 24'h11);
        chk("R10 16bpp flag", 32'(cfg_misalign), 32'd1);
        pix(11'd12, 11'd30, 1'b0, 1'b0, 4'h0);
        chk("R10 16bpp hit", 32'(out_hit), 32'd1);
        wr(2'd0, 24'h21);
        chk("R10 24bpp flag", 32'(cfg_misalign), 32'd0);
        pix(11'd12, 11'd30, 1'b0, 1'b0, 4'h0);
        chk("R10 24bpp unmasked", 32'(out_hit), 32'd0);
        wr(2'd1, 24'((14 << 11) | 20));
        wr(2'd0, 24'h11);
        chk("R10 16bpp aligned", 32'(cfg_misalign), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule